// File: doc/BRIEF.md
# Edge-Triggered Interrupt and Event Line Controller

This block watches sixteen interrupt lines, each fed by the same-numbered pin of a port chosen for that line. Every pin is brought into the clock domain by a two-flop synchronizer. The selected, synchronized level of each line is then compared with its previous value to find rising and falling transitions. Each line has its own enables for the two edge directions.

A detected edge does one of two things. On a line with its event mask clear, it latches a pending flag. The flag drives the line's interrupt output whenever the line's interrupt mask is set, and software clears the flag by writing a one to it. On a line with its event mask set, the edge instead produces a one-cycle pulse on the line's event output and leaves the pending flag alone.

All configuration is held in a small register file on a simple write-strobe bus with a combinational read path. Writing a port selection reloads that line's edge history from the newly selected pin, so switching ports does not on its own raise an edge.

Top module: `edge_irq_ctrl`

## Requirements
- R1: Line n is driven only by pin n of the port selected for it. Pins are packed port-major, so port p pin n sits at index p*16+n of `port_pins`.
- R2: Line n's 4-bit port selector is stored at register address 5+(n>>2), in bits 4*(n&3)+3 down to 4*(n&3). Reading the register returns the stored value.
- R3: Each line has a rising-edge enable and a falling-edge enable. A transition in a disabled direction is ignored. With both enables set, either transition triggers the line.
- R4: Register map: address 0 holds the rising enables, 1 the falling enables, 2 the interrupt mask, 3 the event mask and 4 the pending flags. Addresses 5 to 8 hold the port selectors. Bit n of each of these registers belongs to line n. Any other address reads as zero.
- R5: Every pin passes through two synchronizing flops. A pin change first sampled at clock edge k sets the pending flag at edge k+2.
- R6: An edge on a line whose event mask is clear sets the line's pending flag, whatever the line's interrupt mask. The flag stays set until it is cleared.
- R7: `irq_out[n]` equals pending flag n ANDed with interrupt mask bit n.
- R8: An edge on a line whose event mask is set gives a one-cycle high on `evt_out[n]`, at the same clock edge that would otherwise set the pending flag. It does not set the pending flag.
- R9: After reset, every register reads zero and both output vectors are zero.
- R10: Writing a line's port selector does not by itself produce an edge on that line. A later real transition of the newly selected pin is still detected.
- R11: A selector value equal to or greater than NUM_PORTS feeds the line a constant 0, so that line never triggers.
- R12: Writing to address 4 clears each pending flag whose data bit is 1. A data bit of 0 leaves its flag unchanged. If an edge and a clear hit the same flag in the same cycle, the flag stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register address |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data (combinational from reg_addr) |
| port_pins | input | NUM_PORTS*16 | Raw pins, port-major |
| irq_out | output | 16 | Per-line interrupt request |
| evt_out | output | 16 | Per-line event pulse |

## Verification
The bench builds the block with NUM_PORTS set to 3. With that setting, selector values 3 to 15 are out of range, so both random selector writes and a directed case reach the constant-zero input path. Three ports are still enough to switch a line between two pins held at different levels, which exercises the history reload on a selector write. Random traffic mixes pin toggles with writes to every address, so edge-against-clear collisions and selector changes on active lines occur alongside the directed checks.

// File: rtl/edge_irq_pkg.sv
package edge_irq_pkg;
  localparam int LINES       = 16;
  localparam int SEL_W       = 4;
  localparam int DATA_W      = 16;
  localparam int ADDR_W      = 4;
  localparam int SEL_PER_REG = DATA_W / SEL_W;
  localparam int SEL_REGS    = LINES / SEL_PER_REG;
  localparam int A_SEL0_I    = 5;

  localparam logic [ADDR_W-1:0] A_RISE = 4'd0;
  localparam logic [ADDR_W-1:0] A_FALL = 4'd1;
  localparam logic [ADDR_W-1:0] A_IMSK = 4'd2;
  localparam logic [ADDR_W-1:0] A_EMSK = 4'd3;
  localparam logic [ADDR_W-1:0] A_PEND = 4'd4;

  typedef logic [LINES-1:0] line_vec_t;
endpackage

// File: rtl/edge_irq_sync.sv
module edge_irq_sync #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [W-1:0] st1_q, st2_q;
  logic [W-1:0] st1_d, st2_d;

  always_comb begin
    st1_d = din;
    st2_d = st1_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st1_q <= '0;
      st2_q <= '0;
    end else begin
      st1_q <= st1_d;
      st2_q <= st2_d;
    end
  end

  assign dout = st2_q;
endmodule

// File: rtl/edge_irq_regs.sv
module edge_irq_regs
  import edge_irq_pkg::*;
(
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   we,
  input  logic [ADDR_W-1:0]      addr,
  input  logic [DATA_W-1:0]      wdata,
  input  line_vec_t              pend,
  output line_vec_t              rise_q,
  output line_vec_t              fall_q,
  output line_vec_t              imsk_q,
  output line_vec_t              emsk_q,
  output logic [LINES*SEL_W-1:0] sel_q,
  output logic [LINES*SEL_W-1:0] sel_d,
  output line_vec_t              pend_clr,
  output logic [DATA_W-1:0]      rdata
);
  line_vec_t rise_d, fall_d, imsk_d, emsk_d;
  logic      cfg_en;

  assign cfg_en = we;

  always_comb begin
    rise_d   = rise_q;
    fall_d   = fall_q;
    imsk_d   = imsk_q;
    emsk_d   = emsk_q;
    sel_d    = sel_q;
    pend_clr = '0;
    if (we) begin
      case (addr)
        A_RISE:  rise_d   = wdata;
        A_FALL:  fall_d   = wdata;
        A_IMSK:  imsk_d   = wdata;
        A_EMSK:  emsk_d   = wdata;
        A_PEND:  pend_clr = wdata;
        default: ;
      endcase
      for (int r = 0; r < SEL_REGS; r++) begin
        if (addr == ADDR_W'(A_SEL0_I + r)) sel_d[r*DATA_W +: DATA_W] = wdata;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rise_q <= '0;
      fall_q <= '0;
      imsk_q <= '0;
      emsk_q <= '0;
      sel_q  <= '0;
    end else if (cfg_en) begin
      rise_q <= rise_d;
      fall_q <= fall_d;
      imsk_q <= imsk_d;
      emsk_q <= emsk_d;
      sel_q  <= sel_d;
    end
  end

  always_comb begin
    rdata = '0;
    case (addr)
      A_RISE:  rdata = rise_q;
      A_FALL:  rdata = fall_q;
      A_IMSK:  rdata = imsk_q;
      A_EMSK:  rdata = emsk_q;
      A_PEND:  rdata = pend;
      default: ;
    endcase
    for (int r = 0; r < SEL_REGS; r++) begin
      if (addr == ADDR_W'(A_SEL0_I + r)) rdata = sel_q[r*DATA_W +: DATA_W];
    end
  end
endmodule

// File: rtl/edge_irq_line.sv
module edge_irq_line
  import edge_irq_pkg::*;
#(
  parameter int NUM_PORTS = 5
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_PORTS-1:0] port_bits,
  input  logic [SEL_W-1:0]     sel_cur,
  input  logic [SEL_W-1:0]     sel_nxt,
  input  logic                 rise_en,
  input  logic                 fall_en,
  input  logic                 evt_en,
  input  logic                 clr,
  output logic                 hit,
  output logic                 pend,
  output logic                 evt
);
  logic cur, reload;
  logic prev_q, pend_q, evt_q;
  logic prev_d, pend_d, evt_d;

  function automatic logic pick(input logic [NUM_PORTS-1:0] bits,
                                input logic [SEL_W-1:0] s);
    logic v;
    v = 1'b0;
    for (int p = 0; p < NUM_PORTS; p++) begin
      if (s == SEL_W'(p)) v = bits[p];
    end
    return v;
  endfunction

  always_comb begin
    cur    = pick(port_bits, sel_cur);
    reload = pick(port_bits, sel_nxt);
    hit    = (cur & ~prev_q & rise_en) | (~cur & prev_q & fall_en);
    prev_d = reload;
    pend_d = (pend_q & ~clr) | (hit & ~evt_en);
    evt_d  = hit & evt_en;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
      pend_q <= 1'b0;
      evt_q  <= 1'b0;
    end else begin
      prev_q <= prev_d;
      pend_q <= pend_d;
      evt_q  <= evt_d;
    end
  end

  assign pend = pend_q;
  assign evt  = evt_q;
endmodule

// File: rtl/edge_irq_ctrl.sv
module edge_irq_ctrl
  import edge_irq_pkg::*;
#(
  parameter int NUM_PORTS = 5
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       reg_we,
  input  logic [3:0]                 reg_addr,
  input  logic [15:0]                reg_wdata,
  output logic [15:0]                reg_rdata,
  input  logic [NUM_PORTS*16-1:0]    port_pins,
  output logic [15:0]                irq_out,
  output logic [15:0]                evt_out
);
  localparam int PIN_W = NUM_PORTS * LINES;

  logic [PIN_W-1:0]       pin_sync;
  line_vec_t              rise_q, fall_q, imsk_q, emsk_q, pend_clr;
  line_vec_t              pend_vec, evt_vec, hit_vec;
  logic [LINES*SEL_W-1:0] sel_q, sel_d;

  edge_irq_sync #(.W(PIN_W)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .din  (port_pins),
    .dout (pin_sync)
  );

  edge_irq_regs u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .we      (reg_we),
    .addr    (reg_addr),
    .wdata   (reg_wdata),
    .pend    (pend_vec),
    .rise_q  (rise_q),
    .fall_q  (fall_q),
    .imsk_q  (imsk_q),
    .emsk_q  (emsk_q),
    .sel_q   (sel_q),
    .sel_d   (sel_d),
    .pend_clr(pend_clr),
    .rdata   (reg_rdata)
  );

  for (genvar n = 0; n < LINES; n++) begin : g_line
    logic [NUM_PORTS-1:0] bits;
    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
      assign bits[p] = pin_sync[p*LINES + n];
    end
    edge_irq_line #(.NUM_PORTS(NUM_PORTS)) u_line (
      .clk      (clk),
      .rst_n    (rst_n),
      .port_bits(bits),
      .sel_cur  (sel_q[n*SEL_W +: SEL_W]),
      .sel_nxt  (sel_d[n*SEL_W +: SEL_W]),
      .rise_en  (rise_q[n]),
      .fall_en  (fall_q[n]),
      .evt_en   (emsk_q[n]),
      .clr      (pend_clr[n]),
      .hit      (hit_vec[n]),
      .pend     (pend_vec[n]),
      .evt      (evt_vec[n])
    );
  end

  assign irq_out = pend_vec & imsk_q;
  assign evt_out = evt_vec;
endmodule

// File: rtl/edge_irq_ctrl_chk.sv
module edge_irq_ctrl_chk
  import edge_irq_pkg::*;
#(
  parameter int NUM_PORTS = 5
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    we,
  input logic [3:0]              addr,
  input logic [15:0]             wdata,
  input logic [NUM_PORTS*16-1:0] sync_bus,
  input line_vec_t               pend_q,
  input line_vec_t               emsk,
  input line_vec_t               edge_vec,
  input logic [15:0]             evt_out
);
  // R12
  pend_w1c_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (we && addr == A_PEND) |=>
      ((pend_q & $past(wdata)) == ($past(edge_vec) & ~$past(emsk) & $past(wdata))));

  // R6
  pend_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> ((($past(pend_q) &
                 ~(($past(we) && $past(addr) == A_PEND) ? $past(wdata) : 16'h0)) &
                ~pend_q) == 16'h0));

  // R8
  evt_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |-> ((evt_out & ~$past(emsk)) == 16'h0));

  // R8
  pend_not_evt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |-> (((pend_q & ~$past(pend_q)) & $past(emsk)) == 16'h0));

  // R10
  no_spurious_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $stable(sync_bus) |-> (edge_vec == 16'h0));
endmodule

bind edge_irq_ctrl edge_irq_ctrl_chk #(.NUM_PORTS(NUM_PORTS)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .we      (reg_we),
  .addr    (reg_addr),
  .wdata   (reg_wdata),
  .sync_bus(pin_sync),
  .pend_q  (pend_vec),
  .emsk    (emsk_q),
  .edge_vec(hit_vec),
  .evt_out (evt_out)
);

// File: tb/sim_edge_irq_ctrl.sv
`timescale 1ns/1ps
module sim_edge_irq_ctrl;
  localparam int NP = 3;
  localparam int PW = NP * 16;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          we;
  logic [3:0]    addr;
  logic [15:0]   wdata, rdata, irq, evt;
  logic [PW-1:0] pins, pv;

  always #4 clk = ~clk;

  edge_irq_ctrl #(.NUM_PORTS(NP)) u0 (
    .clk(clk), .rst_n(rst_n), .reg_we(we), .reg_addr(addr), .reg_wdata(wdata),
    .reg_rdata(rdata), .port_pins(pins), .irq_out(irq), .evt_out(evt)
  );

  logic [PW-1:0] m_s1, m_s2;
  logic [15:0]   m_prev, m_pend, m_evt, m_rise, m_fall, m_imsk, m_emsk;
  logic [63:0]   m_sel;
  int checks = 0;
  int fails  = 0;

  function automatic logic sel_pin(input logic [PW-1:0] s, input logic [3:0] sel, input int line);
    for (int p = 0; p < NP; p++) if (sel == 4'(p)) return s[p*16 + line];
    return 1'b0;
  endfunction

  function automatic logic [15:0] model_read(input logic [3:0] a);
    case (a)
      4'd0: return m_rise;
      4'd1: return m_fall;
      4'd2: return m_imsk;
      4'd3: return m_emsk;
      4'd4: return m_pend;
      4'd5: return m_sel[15:0];
      4'd6: return m_sel[31:16];
      4'd7: return m_sel[47:32];
      4'd8: return m_sel[63:48];
      default: return 16'h0;
    endcase
  endfunction

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step(input logic w, input logic [3:0] a, input logic [15:0] d, input logic [PW-1:0] p);
    logic [15:0] hit, clr, n_rise, n_fall, n_imsk, n_emsk, n_prev;
    logic [63:0] n_sel;
    logic c;
    n_rise = m_rise; n_fall = m_fall; n_imsk = m_imsk; n_emsk = m_emsk; n_sel = m_sel; clr = '0;
    if (w) begin
      case (a)
        4'd0: n_rise = d;
        4'd1: n_fall = d;
        4'd2: n_imsk = d;
        4'd3: n_emsk = d;
        4'd4: clr = d;
        4'd5: n_sel[15:0]  = d;
        4'd6: n_sel[31:16] = d;
        4'd7: n_sel[47:32] = d;
        4'd8: n_sel[63:48] = d;
        default: ;
      endcase
    end
    for (int n = 0; n < 16; n++) begin
      c = sel_pin(m_s2, m_sel[n*4 +: 4], n);
      hit[n] = (c & ~m_prev[n] & m_rise[n]) | (~c & m_prev[n] & m_fall[n]);
      n_prev[n] = sel_pin(m_s2, n_sel[n*4 +: 4], n);
    end
    we = w; addr = a; wdata = d; pins = p;
    @(posedge clk);
    m_pend = (m_pend & ~clr) | (hit & ~m_emsk);
    m_evt  = hit & m_emsk;
    m_prev = n_prev;
    m_s2 = m_s1; m_s1 = p;
    m_rise = n_rise; m_fall = n_fall; m_imsk = n_imsk; m_emsk = n_emsk; m_sel = n_sel;
    @(negedge clk);
    check("R7 irq", irq, m_pend & m_imsk);
    check("R8 evt", evt, m_evt);
    if (a == 4'd4) check("R6 pend read", rdata, model_read(a));
    else if (a >= 4'd5 && a <= 4'd8) check("R2 sel read", rdata, model_read(a));
    else check("R4 reg read", rdata, model_read(a));
  endtask

  task automatic idle(input int k);
    for (int i = 0; i < k; i++) step(1'b0, 4'd0, 16'h0, pv);
  endtask

  task automatic report();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    report();
  end

  initial begin
    void'($urandom(32'd1234));
    rst_n = 1'b0; we = 0; addr = 0; wdata = 0; pins = '0; pv = '0;
    m_s1 = '0; m_s2 = '0; m_prev = '0; m_pend = '0; m_evt = '0;
    m_rise = '0; m_fall = '0; m_imsk = '0; m_emsk = '0; m_sel = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R9 reset state
    check("R9 irq", irq, 16'h0);
    check("R9 evt", evt, 16'h0);
    for (int a = 0; a < 9; a++) begin
      step(1'b0, 4'(a), 16'h0, pv);
      check("R9 reg", rdata, 16'h0);
    end

    // R1 / R2 / R5: line 5 on port 1
    step(1'b1, 4'd6, 16'h0010, pv);
    check("R2 field", rdata, 16'h0010);
    step(1'b1, 4'd0, 16'h0020, pv);
    step(1'b1, 4'd2, 16'h0020, pv);
    pv[5] = 1'b1;
    idle(4);
    check("R1 other port", irq, 16'h0);
    pv[16+5] = 1'b1;
    idle(2);
    check("R5 latency", irq, 16'h0);
    idle(1);
    check("R5 latency", irq, 16'h0020);

    // R12 write zero, write one
    step(1'b1, 4'd4, 16'h0000, pv);
    check("R12 zero write", irq, 16'h0020);
    step(1'b1, 4'd4, 16'h0020, pv);
    check("R12 clear", irq, 16'h0);

    // R3 falling, R12 collision
    step(1'b1, 4'd1, 16'h0020, pv);
    pv[16+5] = 1'b0;
    idle(2);
    step(1'b1, 4'd4, 16'h0020, pv);
    check("R12 edge wins", irq, 16'h0020);
    step(1'b1, 4'd4, 16'h0020, pv);
    check("R3 fall cleared", irq, 16'h0);

    // R8 event on line 6 (port 0)
    step(1'b1, 4'd0, 16'h0060, pv);
    step(1'b1, 4'd3, 16'h0040, pv);
    step(1'b1, 4'd2, 16'h0060, pv);
    pv[6] = 1'b1;
    idle(2);
    check("R8 before", evt, 16'h0);
    idle(1);
    check("R8 pulse", evt, 16'h0040);
    step(1'b0, 4'd4, 16'h0, pv);
    check("R8 one cycle", evt, 16'h0);
    check("R8 no pend", rdata, 16'h0);
    pv[6] = 1'b0;
    idle(4);
    check("R3 rise only", evt, 16'h0);

    // R11 out-of-range selector on line 7
    step(1'b1, 4'd6, 16'h7010, pv);
    check("R2 field7", rdata, 16'h7010);
    step(1'b1, 4'd0, 16'h00E0, pv);
    step(1'b1, 4'd1, 16'h00A0, pv);
    step(1'b1, 4'd2, 16'h00E0, pv);
    step(1'b1, 4'd3, 16'h0000, pv);
    pv[7] = 1'b1; pv[23] = 1'b1; pv[39] = 1'b1;
    idle(4);
    pv[7] = 1'b0; pv[23] = 1'b0; pv[39] = 1'b0;
    idle(4);
    step(1'b0, 4'd4, 16'h0, pv);
    check("R11 pend", rdata, 16'h0);
    check("R11 irq", irq, 16'h0);

    // R10 selector switch on line 8
    pv[2*16+8] = 1'b1;
    step(1'b1, 4'd0, 16'h01E0, pv);
    step(1'b1, 4'd1, 16'h01A0, pv);
    step(1'b1, 4'd2, 16'h01E0, pv);
    idle(3);
    step(1'b1, 4'd7, 16'h0002, pv);
    idle(4);
    check("R10 no edge", irq, 16'h0);
    step(1'b0, 4'd4, 16'h0, pv);
    check("R10 pend", rdata, 16'h0);
    pv[2*16+8] = 1'b0;
    idle(3);
    check("R10 real edge", irq, 16'h0100);

    // R4 unmapped and readback
    step(1'b0, 4'hF, 16'h0, pv);
    check("R4 unmapped", rdata, 16'h0);
    step(1'b0, 4'd2, 16'h0, pv);
    check("R4 imask", rdata, 16'h01E0);
    step(1'b1, 4'd4, 16'hFFFF, pv);

    // random traffic
    for (int i = 0; i < 4000; i++) begin
      logic [PW-1:0] f1, f2, f3;
      logic          w;
      f1 = PW'({$urandom, $urandom});
      f2 = PW'({$urandom, $urandom});
      f3 = PW'({$urandom, $urandom});
      pv = pv ^ (f1 & f2 & f3);
      w  = ($urandom % 4) == 0;
      step(w, 4'($urandom % 10), 16'($urandom), pv);
    end
    report();
  end
endmodule